// File: doc/BRIEF.md
# Multi-channel serial ADC capture sequencer

This block runs the acquisition cycle for twelve serial-output converters wired as two banks of six that sample together. It raises one conversion-start pulse that fans out to every converter, waits a programmable settling time, then opens a gate for a burst of eighteen serial clock cycles. During that burst it shifts in one bit per cycle from each of twelve serial data lanes in lockstep. At the end it presents twelve parallel 16-bit words with a one-cycle valid strobe.

The sequence starts on a trigger and then repeats on a programmable period, so samples keep arriving without further software action. Of the eighteen bits in each burst, the first two are alignment bits and are dropped, and the remaining sixteen form the sample, most significant bit first. A sync input returns the sequencer to idle at once and restarts its period count. Boards that share a sync line therefore run their conversions in the same phase.

Top module: `adcCaptureSeq`

## Requirements
- R1: After a start, `convStart` is high for exactly PULSE_W consecutive cycles (default 2). It is one signal shared by all twelve lanes.
- R2: After `convStart` falls, `sclkEn` stays low for `waitCfg` cycles and then is high for exactly 18 consecutive cycles. With `waitCfg` = 0 the burst begins in the cycle right after the pulse.
- R3: Lane i is read from `sdLanes[i]` at the clock edge that ends each `sclkEn` cycle, and every lane uses the same window. The first 2 of the 18 bits are discarded. The 3rd bit becomes bit 15 and the 18th becomes bit 0 of `samples[16*i+15:16*i]`.
- R4: `sampleValid` is high for exactly one cycle, the cycle after the last `sclkEn` cycle. `samples` takes its new value in that same cycle and holds it until the next valid cycle.
- R5: Once armed, conversion starts repeat every `periodCfg` cycles, measured between rising edges of `convStart`. When `periodCfg` is shorter than the sequence, they repeat back to back every PULSE_W + `waitCfg` + 20 cycles.
- R6: With the sequencer idle, a high `trigIn` starts a conversion, with `convStart` high in the next cycle, and arms periodic repetition. No conversion starts before the first trigger. A trigger during a running sequence does not restart it or shift the period.
- R7: A high `syncIn` forces idle in the next cycle. It cuts off any pulse or burst, and an interrupted burst never raises `sampleValid` or changes `samples`. It clears the period count, so an armed sequencer next starts `periodCfg` cycles after the sync edge. Sync takes priority over a simultaneous trigger.
- R8: During and right after reset, `convStart`, `sclkEn` and `sampleValid` are low, `samples` is all zero, and the sequencer is not armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, one serial bit per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| trigIn | input | 1 | Acquisition trigger, level sampled each cycle |
| syncIn | input | 1 | Multi-board realignment, forces idle |
| periodCfg | input | 16 | Cycles between conversion starts |
| waitCfg | input | 8 | Cycles between pulse end and burst start |
| sdLanes | input | 12 | One serial data bit per converter lane |
| convStart | output | 1 | Shared conversion-start pulse |
| sclkEn | output | 1 | Serial clock gate, high for the 18-cycle burst |
| samples | output | 192 | Twelve 16-bit words, lane i at bits 16*i+15..16*i |
| sampleValid | output | 1 | One-cycle strobe marking fresh samples |

## Verification
The bench attacks the capture window edges with random lane data on every cycle. A design that kept the alignment bits, or that dropped the last bits instead, would show the sample shifted by two places against the reference. Sync is asserted in the middle of a burst. A design that still published the partial word, or that kept its old period count, would raise a stray valid or start its next conversion at the wrong cycle. Periods both shorter and longer than the sequence are run, along with zero and non-zero wait times and a trigger landing mid-burst. These cases expose an off-by-one in the period compare, a skipped or extra wait cycle, and a trigger that wrongly restarts the sequence.

// File: rtl/adcSeqPkg.sv
`timescale 1ns/1ps
package adcSeqPkg;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_CONV,
    SEQ_WAIT,
    SEQ_READ,
    SEQ_PRESENT
  } seqState_t;

  // Strobes from the controller to the lane datapath
  typedef struct packed {
    logic shiftEn;   // take one payload bit from every lane
    logic loadOut;   // final bit: publish the assembled words
  } dpStrobe_t;

endpackage

// File: rtl/adcLaneShifter.sv
`timescale 1ns/1ps
module adcLaneShifter #(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                shiftEn,
  input  logic                loadEn,
  input  logic                serialBit,
  output logic [SAMPLE_W-1:0] sampleOut
);

  logic [SAMPLE_W-1:0] shiftReg;
  logic [SAMPLE_W-1:0] shiftNext;

  assign shiftNext = {shiftReg[SAMPLE_W-2:0], serialBit};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (shiftEn) begin
      shiftReg <= shiftNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleOut <= '0;
    end else if (loadEn) begin
      sampleOut <= shiftNext;
    end
  end

  // R4
  hold_between_loads_chk: assert property (@(posedge clk) disable iff (!rstN)
    !loadEn |=> $stable(sampleOut));

  // R3
  last_bit_lsb_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> sampleOut[0] == $past(serialBit));

endmodule

// File: rtl/adcSeqDatapath.sv
`timescale 1ns/1ps
module adcSeqDatapath
  import adcSeqPkg::*;
#(
  parameter int NUM_LANES = 12,
  parameter int SAMPLE_W  = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  dpStrobe_t                     strobe,
  input  logic [NUM_LANES-1:0]          sdLanes,
  output logic [NUM_LANES*SAMPLE_W-1:0] samples
);

  for (genvar lane = 0; lane < NUM_LANES; lane++) begin : g_lane
    logic [SAMPLE_W-1:0] laneWord;

    adcLaneShifter #(
      .SAMPLE_W(SAMPLE_W)
    ) i_shift (
      .clk       (clk),
      .rstN      (rstN),
      .shiftEn   (strobe.shiftEn),
      .loadEn    (strobe.loadOut),
      .serialBit (sdLanes[lane]),
      .sampleOut (laneWord)
    );

    assign samples[lane*SAMPLE_W +: SAMPLE_W] = laneWord;
  end

endmodule

// File: rtl/adcSeqControl.sv
`timescale 1ns/1ps
module adcSeqControl
  import adcSeqPkg::*;
#(
  parameter int PULSE_W    = 2,
  parameter int SAMPLE_W   = 16,
  parameter int ALIGN_BITS = 2,
  parameter int PERIOD_W   = 16,
  parameter int WAIT_W     = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                trigIn,
  input  logic                syncIn,
  input  logic [PERIOD_W-1:0] periodCfg,
  input  logic [WAIT_W-1:0]   waitCfg,
  output logic                convStart,
  output logic                sclkEn,
  output logic                sampleValid,
  output dpStrobe_t           strobe
);

  localparam int BURST_LEN = SAMPLE_W + ALIGN_BITS;
  localparam int BURST_CW  = $clog2(BURST_LEN + 1);
  localparam int PULSE_CW  = $clog2(PULSE_W + 1);
  localparam int CNT_A     = (BURST_CW > PULSE_CW) ? BURST_CW : PULSE_CW;
  localparam int CNT_W     = (CNT_A > WAIT_W) ? CNT_A : WAIT_W;
  localparam int PCW       = PERIOD_W + 1;
  localparam int MON_W     = CNT_A + 2;

  seqState_t           state, stateNext;
  logic [CNT_W-1:0]    stepCnt, stepNext;
  logic [PERIOD_W-1:0] periodCnt;
  logic                armed;
  logic                periodHit;
  logic                startReq;
  logic                startGo;

  // Period expires when the cycles since the last start reach periodCfg - 1
  assign periodHit = ({1'b0, periodCnt} + PCW'(1)) >= {1'b0, periodCfg};
  assign startReq  = (state == SEQ_IDLE) && (trigIn || (armed && periodHit));
  assign startGo   = startReq && !syncIn;

  always_comb begin
    stateNext = state;
    stepNext  = stepCnt;
    unique case (state)
      SEQ_IDLE: begin
        if (startReq) begin
          stateNext = SEQ_CONV;
          stepNext  = CNT_W'(PULSE_W - 1);
        end
      end
      SEQ_CONV: begin
        if (stepCnt == '0) begin
          if (waitCfg == '0) begin
            stateNext = SEQ_READ;
            stepNext  = CNT_W'(BURST_LEN - 1);
          end else begin
            stateNext = SEQ_WAIT;
            stepNext  = CNT_W'(waitCfg - 1'b1);
          end
        end else begin
          stepNext = stepCnt - 1'b1;
        end
      end
      SEQ_WAIT: begin
        if (stepCnt == '0) begin
          stateNext = SEQ_READ;
          stepNext  = CNT_W'(BURST_LEN - 1);
        end else begin
          stepNext = stepCnt - 1'b1;
        end
      end
      SEQ_READ: begin
        if (stepCnt == '0) begin
          stateNext = SEQ_PRESENT;
        end else begin
          stepNext = stepCnt - 1'b1;
        end
      end
      SEQ_PRESENT: stateNext = SEQ_IDLE;
      default:     stateNext = SEQ_IDLE;
    endcase
    if (syncIn) begin
      stateNext = SEQ_IDLE;
      stepNext  = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= SEQ_IDLE;
      stepCnt <= '0;
    end else begin
      state   <= stateNext;
      stepCnt <= stepNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodCnt <= '0;
      armed     <= 1'b0;
    end else begin
      armed <= armed | trigIn;
      if (syncIn || startGo) begin
        periodCnt <= '0;
      end else if (periodCnt != '1) begin
        periodCnt <= periodCnt + 1'b1;
      end
    end
  end

  assign convStart   = (state == SEQ_CONV);
  assign sclkEn      = (state == SEQ_READ);
  assign sampleValid = (state == SEQ_PRESENT);

  // The down-counter runs 17..0 in the burst; the alignment bits are the top two counts
  assign strobe.shiftEn = sclkEn && (stepCnt < CNT_W'(SAMPLE_W)) && !syncIn;
  assign strobe.loadOut = sclkEn && (stepCnt == '0) && !syncIn;

  // Run-length monitors kept apart from the sequencing counter
  logic [MON_W-1:0] convRun;
  logic [MON_W-1:0] burstRun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      convRun  <= '0;
      burstRun <= '0;
    end else begin
      convRun  <= convStart ? convRun + 1'b1 : '0;
      burstRun <= sclkEn ? burstRun + 1'b1 : '0;
    end
  end

  // R1
  conv_width_max_chk: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> convRun < MON_W'(PULSE_W));

  // R1
  conv_width_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(convStart) && !$past(syncIn)) |-> convRun == MON_W'(PULSE_W));

  // R2
  burst_len_max_chk: assert property (@(posedge clk) disable iff (!rstN)
    sclkEn |-> burstRun < MON_W'(BURST_LEN));

  // R4
  valid_after_full_burst_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> burstRun == MON_W'(BURST_LEN));

  // R7
  sync_to_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    syncIn |=> (state == SEQ_IDLE) && !sampleValid && !sclkEn);

  // R6
  trig_starts_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == SEQ_IDLE && trigIn && !syncIn) |=> convStart);

endmodule

// File: rtl/adcCaptureSeq.sv
`timescale 1ns/1ps
module adcCaptureSeq
  import adcSeqPkg::*;
#(
  parameter int NUM_LANES  = 12,
  parameter int SAMPLE_W   = 16,
  parameter int ALIGN_BITS = 2,
  parameter int PULSE_W    = 2,
  parameter int PERIOD_W   = 16,
  parameter int WAIT_W     = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          trigIn,
  input  logic                          syncIn,
  input  logic [PERIOD_W-1:0]           periodCfg,
  input  logic [WAIT_W-1:0]             waitCfg,
  input  logic [NUM_LANES-1:0]          sdLanes,
  output logic                          convStart,
  output logic                          sclkEn,
  output logic [NUM_LANES*SAMPLE_W-1:0] samples,
  output logic                          sampleValid
);

  dpStrobe_t strobe;

  adcSeqControl #(
    .PULSE_W    (PULSE_W),
    .SAMPLE_W   (SAMPLE_W),
    .ALIGN_BITS (ALIGN_BITS),
    .PERIOD_W   (PERIOD_W),
    .WAIT_W     (WAIT_W)
  ) i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .trigIn      (trigIn),
    .syncIn      (syncIn),
    .periodCfg   (periodCfg),
    .waitCfg     (waitCfg),
    .convStart   (convStart),
    .sclkEn      (sclkEn),
    .sampleValid (sampleValid),
    .strobe      (strobe)
  );

  adcSeqDatapath #(
    .NUM_LANES (NUM_LANES),
    .SAMPLE_W  (SAMPLE_W)
  ) i_data (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .sdLanes (sdLanes),
    .samples (samples)
  );

endmodule

// File: tb/test_adcCaptureSeq.sv
`timescale 1ns/1ps
module test_adcCaptureSeq;

  localparam int LANES = 12;
  localparam int SW    = 16;
  localparam int AB    = 2;
  localparam int PW    = 2;
  localparam int BURST = SW + AB;

  logic                clk = 1'b0;
  logic                rstN;
  logic                trigIn;
  logic                syncIn;
  logic [15:0]         periodCfg;
  logic [7:0]          waitCfg;
  logic [LANES-1:0]    sdLanes;
  logic                convStart;
  logic                sclkEn;
  logic [LANES*SW-1:0] samples;
  logic                sampleValid;

  always #2.5 clk = ~clk;

  adcCaptureSeq i_adcCaptureSeq (
    .clk         (clk),
    .rstN        (rstN),
    .trigIn      (trigIn),
    .syncIn      (syncIn),
    .periodCfg   (periodCfg),
    .waitCfg     (waitCfg),
    .sdLanes     (sdLanes),
    .convStart   (convStart),
    .sclkEn      (sclkEn),
    .samples     (samples),
    .sampleValid (sampleValid)
  );

  int testCnt = 0;
  int failCnt = 0;
  int cycCnt  = 0;
  int validCnt = 0;
  int riseQ[$];
  bit checking = 0;
  bit prevConv = 0;

  // Behavioural reference: phase counted from each conversion start
  bit          mBusy, mArmed;
  int          mPhase, mSince, mWait;
  logic [SW-1:0] accW [LANES];
  logic [SW-1:0] expS [LANES];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: got %0d expected %0d (cycle %0d)", req, what, act, exp, cycCnt);
    end
  endtask

  task automatic chkWide(input bit ok, input string req,
                         input logic [LANES*SW-1:0] act, input logic [LANES*SW-1:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s samples: got %h expected %h (cycle %0d)", req, act, exp, cycCnt);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mArmed = 0; mPhase = 0; mSince = 0; mWait = 0; cycCnt = 0;
      for (int l = 0; l < LANES; l++) begin accW[l] = '0; expS[l] = '0; end
    end else begin
      bit startNow;
      int idx;
      cycCnt++;
      if (mBusy && !syncIn) begin
        idx = mPhase - (PW + mWait);
        if (idx >= 0 && idx < BURST) begin
          for (int l = 0; l < LANES; l++) begin
            if (idx >= AB) accW[l] = {accW[l][SW-2:0], sdLanes[l]};
            if (idx == BURST - 1) expS[l] = accW[l];
          end
        end
      end
      startNow = !mBusy && !syncIn && (trigIn || (mArmed && (mSince + 1 >= int'(periodCfg))));
      if (syncIn) begin
        mBusy = 0; mSince = 0;
      end else if (startNow) begin
        mBusy = 1; mPhase = 0; mSince = 0; mWait = int'(waitCfg);
      end else begin
        if (mSince < 65535) mSince++;
        if (mBusy) begin
          mPhase++;
          if (mPhase > PW + mWait + BURST) mBusy = 0;
        end
      end
      if (trigIn) mArmed = 1;
    end
  end

  always @(negedge clk) begin
    if (rstN && checking) begin
      bit eConv, eSclk, eValid;
      logic [LANES*SW-1:0] eFlat;
      eConv  = mBusy && (mPhase < PW);
      eSclk  = mBusy && (mPhase >= PW + mWait) && (mPhase < PW + mWait + BURST);
      eValid = mBusy && (mPhase == PW + mWait + BURST);
      for (int l = 0; l < LANES; l++) eFlat[l*SW +: SW] = expS[l];
      chk(convStart === eConv, "R1", "convStart", convStart, eConv);
      chk(sclkEn === eSclk, "R2", "sclkEn", sclkEn, eSclk);
      chk(sampleValid === eValid, "R4", "sampleValid", sampleValid, eValid);
      chkWide(samples === eFlat, "R3", samples, eFlat);
      if (sampleValid) validCnt++;
    end
    if (rstN) begin
      if (convStart && !prevConv) riseQ.push_back(cycCnt);
      prevConv = convStart;
    end
    sdLanes = LANES'($urandom);
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic waitRises(input int n);
    int base;
    base = riseQ.size();
    while (riseQ.size() < base + n) tick();
  endtask

  task automatic doSync(input int p, input int w);
    syncIn = 1; periodCfg = 16'(p); waitCfg = 8'(w);
    tick();
    syncIn = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    testCnt++; failCnt++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    int syncAt, vSnap, n0;
    logic [LANES*SW-1:0] sSnap;
    rstN = 0; trigIn = 0; syncIn = 0; periodCfg = 16'd40; waitCfg = 8'd3; sdLanes = '0;
    repeat (4) tick();
    rstN = 1;
    tick();
    // R8 reset state
    chk(convStart == 0, "R8", "convStart", convStart, 0);
    chk(sclkEn == 0, "R8", "sclkEn", sclkEn, 0);
    chk(sampleValid == 0, "R8", "sampleValid", sampleValid, 0);
    chkWide(samples == '0, "R8", samples, '0);
    checking = 1;

    // R6: nothing starts before a trigger
    repeat (10) tick();
    chk(riseQ.size() == 0, "R6", "starts before trigger", riseQ.size(), 0);

    // R6: trigger starts next cycle
    trigIn = 1; tick(); trigIn = 0;
    chk(convStart == 1, "R6", "convStart after trigger", convStart, 1);

    // R5: long period
    waitRises(2);
    chk(riseQ[$] - riseQ[$-1] == 40, "R5", "period 40", riseQ[$] - riseQ[$-1], 40);

    // R6: trigger during a burst changes nothing
    while (!sclkEn) tick();
    n0 = riseQ.size();
    trigIn = 1; tick(); trigIn = 0;
    waitRises(1);
    chk(riseQ[$] - riseQ[n0-1] == 40, "R6", "interval after busy trigger",
        riseQ[$] - riseQ[n0-1], 40);

    // R7: sync in the middle of a burst
    while (!sclkEn) tick();
    repeat (5) tick();
    sSnap = samples; vSnap = validCnt; syncAt = cycCnt;
    doSync(30, 0);
    chk(sclkEn == 0, "R7", "sclkEn after sync", sclkEn, 0);
    chk(convStart == 0, "R7", "convStart after sync", convStart, 0);
    waitRises(1);
    chk(riseQ[$] == syncAt + 1 + 30, "R7", "restart cycle", riseQ[$], syncAt + 31);
    chk(validCnt == vSnap, "R7", "valid from cut burst", validCnt, vSnap);
    chkWide(samples == sSnap, "R7", samples, sSnap);

    // R5 / R2: zero wait, period longer than sequence
    waitRises(1);
    chk(riseQ[$] - riseQ[$-1] == 30, "R5", "period 30 wait 0", riseQ[$] - riseQ[$-1], 30);

    // R5: back to back, wait 3
    doSync(5, 3);
    waitRises(3);
    chk(riseQ[$] - riseQ[$-1] == PW + 3 + 20, "R5", "back to back wait 3",
        riseQ[$] - riseQ[$-1], PW + 23);

    // R5: back to back, wait 0
    doSync(5, 0);
    waitRises(3);
    chk(riseQ[$] - riseQ[$-1] == PW + 20, "R5", "back to back wait 0",
        riseQ[$] - riseQ[$-1], PW + 20);

    // R7: sync wins over a simultaneous trigger
    syncAt = cycCnt;
    trigIn = 1;
    doSync(100, 1);
    trigIn = 0;
    chk(convStart == 0, "R7", "sync over trigger", convStart, 0);
    waitRises(1);
    chk(riseQ[$] == syncAt + 1 + 100, "R7", "restart after sync+trigger", riseQ[$], syncAt + 101);

    waitRises(1);
    repeat (30) tick();
    chk(validCnt > 5, "R4", "valid strobes seen", validCnt, 6);
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule